// File: doc/BRIEF.md
# Dual-Channel Net Pulse Counter

This block takes two step-command pulse trains, one meaning a forward step and one meaning a reverse step, and keeps a separate up-counter for each. Every pulse on either line is counted as a positive increment in its own counter, whichever direction it stands for. The signed net position is formed by subtracting the reverse count from the forward count. A flag shows which line produced the most recent step.

Each line is resynchronised into the block clock and counted on the rising edge of the resynchronised level. A single polarity select inverts both lines before synchronisation, so trains that idle high and pulse low are counted on their leading (falling) edges. A synchronous clear zeroes both counters and the direction flag together. The block sits between a step/direction-style command source and a position loop, which reads the net position.

Top module: `pulse_net_counter`

## Requirements
- R1: Each rising edge of the effective forward level (cw_in XOR invert_in) adds exactly one to cw_count.
- R2: Each rising edge of the effective reverse level (ccw_in XOR invert_in) adds exactly one to ccw_count.
- R3: net_count always equals cw_count minus ccw_count in two's complement of the counter width, with no register on the way.
- R4: dir_up becomes 1 when only the forward counter advances and 0 when only the reverse counter advances; it holds its value when both or neither advance in the same cycle.
- R5: With invert_in at 1, low-going pulses on an idle-high line are counted once each, and a high idle level produces no count.
- R6: A cycle with clr at 1 leaves both counters and dir_up at 0 on the next clock edge, taking priority over any edge counted in that cycle.
- R7: After reset both counters, net_count and dir_up read 0.
- R8: A change on a raw input is reflected in its counter after exactly three rising clock edges, and not after two.
- R9: A run of 4000 forward, then 4000 reverse, then 4000 forward pulses leaves cw_count at 8000, ccw_count at 4000 and net_count at +4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_in | input | 1 | Forward step line, asynchronous |
| ccw_in | input | 1 | Reverse step line, asynchronous |
| invert_in | input | 1 | 1 selects active-low polarity for both lines |
| clr | input | 1 | Synchronous clear of counters and direction flag |
| cw_count | output | W | Forward pulse count |
| ccw_count | output | W | Reverse pulse count |
| net_count | output | W | Signed net position, forward minus reverse |
| dir_up | output | 1 | 1 if the latest step was forward, 0 if reverse or cleared |

## Verification
The assertions assume each raw line stays at a level long enough for the two-flop synchroniser to see every high and low phase, so that one step moves a counter by at most one per cycle, and they assume the polarity select only changes while both lines are idle. The stimulus holds every pulse phase for two clock cycles and changes invert_in in the same cycle that it moves both lines to their new idle level, so the effective level never shows a false edge. Simultaneous activity on both lines is driven only in the dedicated hold-direction scenario.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
  localparam int PNC_NUM_CH  = 2;
  localparam int PNC_CH_FWD  = 0;
  localparam int PNC_CH_REV  = 1;
  localparam int PNC_SYNC_STAGES = 2;
endpackage

// File: rtl/pnc_edge_sync.sv
module pnc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  // polarity applied ahead of the synchroniser
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], raw ^ invert};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pnc_counter.sv
module pnc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] STEP = W'(1);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pnc_dir_track.sv
module pnc_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fwd_inc,
  input  logic rev_inc,
  output logic dir_up
);
  logic dir_q, dir_d, dir_en;

  always_comb begin
    dir_en = clr | (fwd_inc ^ rev_inc);
    dir_d  = clr ? 1'b0 : fwd_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= dir_d;
  end

  assign dir_up = dir_q;
endmodule

// File: rtl/pulse_net_counter.sv
module pulse_net_counter
  import pnc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cw_in,
  input  logic                ccw_in,
  input  logic                invert_in,
  input  logic                clr,
  output logic [W-1:0]        cw_count,
  output logic [W-1:0]        ccw_count,
  output logic signed [W-1:0] net_count,
  output logic                dir_up
);
  logic [PNC_NUM_CH-1:0] raw_ch;
  logic [PNC_NUM_CH-1:0] rise_ch;
  logic [W-1:0]          cnt_ch [PNC_NUM_CH];

  assign raw_ch[PNC_CH_FWD] = cw_in;
  assign raw_ch[PNC_CH_REV] = ccw_in;

  for (genvar g = 0; g < PNC_NUM_CH; g++) begin : g_chan
    pnc_edge_sync #(.STAGES(PNC_SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_ch[g]),
      .invert (invert_in),
      .rise   (rise_ch[g])
    );
    pnc_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (rise_ch[g]),
      .count (cnt_ch[g])
    );
  end

  pnc_dir_track u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .fwd_inc (rise_ch[PNC_CH_FWD]),
    .rev_inc (rise_ch[PNC_CH_REV]),
    .dir_up  (dir_up)
  );

  assign cw_count  = cnt_ch[PNC_CH_FWD];
  assign ccw_count = cnt_ch[PNC_CH_REV];
  assign net_count = $signed(cnt_ch[PNC_CH_FWD] - cnt_ch[PNC_CH_REV]);
endmodule

// File: rtl/pnc_checker.sv
module pnc_checker #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic [W-1:0]        cw_count,
  input logic [W-1:0]        ccw_count,
  input logic signed [W-1:0] net_count,
  input logic                dir_up
);
  localparam logic [W-1:0] ONE = W'(1);

  // R1: forward counter moves by at most one per cycle
  a_r1_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cw_count == $past(cw_count) || cw_count == $past(cw_count) + ONE));

  // R2: reverse counter moves by at most one per cycle
  a_r2_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ccw_count == $past(ccw_count) || ccw_count == $past(ccw_count) + ONE));

  // R3: net position tracks the difference of the two counter deltas
  a_r3_net_delta: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($unsigned(net_count) - $unsigned($past(net_count)) ==
              (cw_count - $past(cw_count)) - (ccw_count - $past(ccw_count))));

  // R4: a lone forward step sets the flag, a lone reverse step clears it
  a_r4_dir_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && cw_count != $past(cw_count) && ccw_count == $past(ccw_count)) |-> dir_up);
  a_r4_dir_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && ccw_count != $past(ccw_count) && cw_count == $past(cw_count)) |-> !dir_up);

  // R6: clear zeroes everything on the next edge
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cw_count == '0 && ccw_count == '0 && !dir_up));
endmodule

bind pulse_net_counter pnc_checker #(.W(W)) u_pnc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .cw_count  (cw_count),
  .ccw_count (ccw_count),
  .net_count (net_count),
  .dir_up    (dir_up)
);

// File: tb/test_pulse_net_counter.sv
module test_pulse_net_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk, rst_n, cw_in, ccw_in, invert_in, clr;
  logic [W-1:0] cw_count, ccw_count;
  logic signed [W-1:0] net_count;
  logic dir_up;

  int n_vec, n_bad;
  logic done;
  longint exp_cw, exp_ccw;
  logic exp_dir;

  pulse_net_counter #(.W(W)) i_pulse_net_counter (
    .clk(clk), .rst_n(rst_n), .cw_in(cw_in), .ccw_in(ccw_in),
    .invert_in(invert_in), .clr(clr), .cw_count(cw_count),
    .ccw_count(ccw_count), .net_count(net_count), .dir_up(dir_up)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " cw_count"}, longint'(cw_count), exp_cw);
    chk({req, " ccw_count"}, longint'(ccw_count), exp_ccw);
    chk({req, " net_count R3"}, longint'(net_count), exp_cw - exp_ccw);
    chk({req, " dir_up"}, longint'(dir_up), longint'(exp_dir));
  endtask

  function automatic logic act_lvl();
    return ~invert_in;
  endfunction

  task automatic pulse(input bit fwd, input bit rev);
    @(negedge clk);
    if (fwd) cw_in = act_lvl();
    if (rev) ccw_in = act_lvl();
    repeat (2) @(negedge clk);
    cw_in = ~act_lvl();
    ccw_in = ~act_lvl();
    repeat (1) @(negedge clk);
    if (fwd) exp_cw++;
    if (rev) exp_ccw++;
    if (fwd && !rev) exp_dir = 1'b1;
    if (rev && !fwd) exp_dir = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_cw = 0; exp_ccw = 0; exp_dir = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cw_in = 1'b0; ccw_in = 1'b0; invert_in = 1'b0; clr = 1'b0;
    exp_cw = 0; exp_ccw = 0; exp_dir = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_all("R7 reset");
  endtask

  task automatic t_forward();
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    settle();
    check_all("R1 R4 forward burst");
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 9; i++) pulse(1'b0, 1'b1);
    settle();
    check_all("R2 R4 reverse burst, negative net");
  endtask

  task automatic t_both();
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    settle();
    check_all("R4 simultaneous holds dir");
  endtask

  task automatic t_latency();
    longint base = exp_cw;
    @(negedge clk); cw_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no change after two edges", longint'(cw_count), base);
    @(negedge clk);
    chk("R8 change after three edges", longint'(cw_count), base + 1);
    cw_in = 1'b0;
    exp_cw = base + 1; exp_dir = 1'b1;
    settle();
  endtask

  task automatic t_clear();
    pulse(1'b1, 1'b0);
    @(negedge clk); cw_in = 1'b1;
    // clear lands on the same cycle the edge is counted
    @(negedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; cw_in = 1'b0;
    exp_cw = 0; exp_ccw = 0; exp_dir = 1'b0;
    settle();
    check_all("R6 clear wins over edge");
  endtask

  task automatic t_active_low();
    @(negedge clk);
    invert_in = 1'b1; cw_in = 1'b1; ccw_in = 1'b1;
    settle();
    do_clear();
    repeat (10) @(negedge clk);
    check_all("R5 idle high no count");
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    for (int i = 0; i < 7; i++) pulse(1'b0, 1'b1);
    settle();
    check_all("R5 active-low pulses");
    @(negedge clk);
    invert_in = 1'b0; cw_in = 1'b0; ccw_in = 1'b0;
    settle();
    do_clear();
    settle();
  endtask

  task automatic t_long_run();
    do_clear();
    for (int i = 0; i < 4000; i++) pulse(1'b1, 1'b0);
    for (int i = 0; i < 4000; i++) pulse(1'b0, 1'b1);
    for (int i = 0; i < 4000; i++) pulse(1'b1, 1'b0);
    settle();
    chk("R9 forward total", longint'(cw_count), 8000);
    chk("R9 reverse total", longint'(ccw_count), 4000);
    chk("R9 net total", longint'(net_count), 4000);
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0;
    t_reset();
    t_forward();
    t_reverse();
    t_both();
    t_latency();
    t_clear();
    t_active_low();
    t_long_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule